// File: doc/BRIEF.md
# Codec command and status slot controller

This block sits on the host side of a serial audio codec link and handles the two control slots of each frame. Software loads a codec register address and a direction flag into a 32-bit command address register, and 16 bits of write data into a data register. It then sets a start bit. At the next frame boundary the block puts the command on the serial output. The data goes in the data slot and the address goes in the address slot, with matching valid bits in the 16-bit tag.

When the codec answers a read, the block checks the incoming tag. It takes the returned status address and the slot-request bits from incoming slot 1 and the returned data from incoming slot 2. It then sets a ready flag, which software clears by writing 1 to it.

A pairing control bit chooses how a write is sent. With the bit set, both slots of a write go out in one frame. With it clear, the data slot is sent alone in one frame and the address slot alone in the frame after it.

The serial side runs on the bit clock, which is the block clock `clk`. A frame is 256 bit times: a 16-bit tag followed by twelve 20-bit slots, each sent MSB first. Outputs change on the rising edge and `sdi_i` is sampled on the falling edge.

Register map, selected by `reg_addr`:

| `reg_addr` | Register | Contents |
|---|---|---|
| 0 | Command address | bit 19 direction, bits 18:12 address, bits 11:2 slot requests, other bits read 0 |
| 1 | Data | bits 15:0 |
| 2 | Control | bit 0 start, bit 1 pairing |
| 3 | Status | bit 0 ready |

Top module: `cslot_ctrl`

## Requirements
- R1: While reset is held, all four registers read 0 and both `sync_o` and `sdo_o` are 0.
- R2: Frames repeat every 256 clocks. `sync_o` is high for the first 16 bit times of each frame, which are the tag, and low for the other 240.
- R3: A frame with no command carries all zeros on `sdo_o`.
- R4: In register 0, bits 31:20 always read 0. Bit 19 (direction, 1 = read) and bits 18:12 (address) are writable. Bits 11:0 cannot be written; bits 11:2 change only when a response is captured, and bits 1:0 always read 0. Register 1 keeps only bits 15:0.
- R5: A command is sent in the frame that begins after the start bit is set. In a command frame the tag bit sent first (tag bit 15) is 1, tag bit 14 marks slot 1 valid and tag bit 13 marks slot 2 valid. Slot 1 is {direction, address, 12 zeros}. A read sends slot 1 only and leaves slot 2 at zero.
- R6: With the pairing bit (register 2 bit 1) at 1, a write sends both slots in one frame, and slot 2 is {data, 4 zeros}.
- R7: With the pairing bit at 0, a write sends slot 2 alone in one frame and slot 1 alone in the next frame.
- R8: The start bit (register 2 bit 0) reads 1 from the moment it is written until the frame that carries slot 1 has ended, and 0 after that.
- R9: Writing 1 to start while a command is pending adds no frame and no repeat. Writing 0 to start has no effect.
- R10: After a read command has been sent, an incoming frame with tag bits 14 and 13 both set is captured as the response. Register 3 bit 0 becomes 1, register 0 bits 18:12 take incoming slot 1 bits 18:12, register 0 bits 11:2 take incoming slot 1 bits 11:2, and register 1 takes incoming slot 2 bits 19:4.
- R11: Two kinds of incoming frame change nothing: a frame with tag bit 13 clear, and a frame that arrives while no read is waiting for a response. A response that is still awaited stays awaited after such a frame.
- R12: Writing 1 to register 3 bit 0 clears the ready flag. Writing 0 to it leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| sync_o | output | 1 | Frame sync, high during the tag |
| sdo_o | output | 1 | Serial data to the codec |
| sdi_i | input | 1 | Serial data from the codec |

## Verification
A wrong frame counter or snapshot shows up on `sync_o` or `sdo_o` within one frame, because the whole serial stream is compared against a model bit by bit. A start bit that is stuck, cleared early or re-armed has two symptoms. It shows as a missing, early or repeated command frame one boundary later, and as a wrong start value on the control read in the middle of the next frame. A wrong awaiting state, or a wrong capture of the response, shows in the status and address reads within the frame that carries the response.

// File: rtl/cslot_pkg.sv
package cslot_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int N_SLOTS   = 12;
  localparam int CA_W      = 7;
  localparam int CD_W      = 16;
  localparam int REQ_W     = N_SLOTS - 2;
  localparam int FRAME_LEN = TAG_W + N_SLOTS * SLOT_W;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam int HEAD_W    = TAG_W + 2 * SLOT_W;
  localparam int HIDX_W    = $clog2(HEAD_W);
  localparam int S1_END    = TAG_W + SLOT_W;
  localparam int S2_END    = HEAD_W;
  localparam int RW_POS    = 19;
  localparam int CA_LO     = 12;
  localparam int REQ_LO    = 2;

  typedef enum logic [1:0] {
    REG_CMDA = 2'd0,
    REG_CMDD = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic            v1;
    logic            v2;
    logic            rw;
    logic [CA_W-1:0] ca;
    logic [CD_W-1:0] cd;
  } cmd_snap_t;
endpackage

// File: rtl/cslot_regs.sv
module cslot_regs
  import cslot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             clr_start_i,
  input  logic             rd_sent_i,
  input  logic             rsp_valid_i,
  input  logic [CA_W-1:0]  rsp_ca_i,
  input  logic [REQ_W-1:0] rsp_req_i,
  input  logic [CD_W-1:0]  rsp_cd_i,
  output logic             start_o,
  output logic             atomic_o,
  output logic             rw_o,
  output logic [CA_W-1:0]  ca_o,
  output logic [CD_W-1:0]  cd_o
);
  logic             rw_q, rw_d, start_q, start_d, atomic_q, atomic_d;
  logic             await_q, await_d, ready_q, ready_d;
  logic [CA_W-1:0]  ca_q, ca_d;
  logic [REQ_W-1:0] req_q, req_d;
  logic [CD_W-1:0]  cd_q, cd_d;
  logic             wr_a, wr_d, wr_c, wr_s, rsp_take;
  logic             en_a, en_d, en_c, en_flags;
  logic             unused_hi;

  assign unused_hi = ^reg_wdata[31:20];
  assign wr_a      = reg_we && (reg_addr == REG_CMDA);
  assign wr_d      = reg_we && (reg_addr == REG_CMDD);
  assign wr_c      = reg_we && (reg_addr == REG_CTRL);
  assign wr_s      = reg_we && (reg_addr == REG_STAT);
  assign rsp_take  = rsp_valid_i && await_q;

  assign en_a     = wr_a || rsp_take;
  assign en_d     = wr_d || rsp_take;
  assign en_c     = wr_c || clr_start_i;
  assign en_flags = rsp_take || rd_sent_i || wr_s;

  always_comb begin
    rw_d     = wr_a ? reg_wdata[RW_POS] : rw_q;
    ca_d     = rsp_take ? rsp_ca_i : (wr_a ? reg_wdata[CA_LO +: CA_W] : ca_q);
    req_d    = rsp_take ? rsp_req_i : req_q;
    cd_d     = rsp_take ? rsp_cd_i : (wr_d ? reg_wdata[CD_W-1:0] : cd_q);
    atomic_d = wr_c ? reg_wdata[1] : atomic_q;
    if (clr_start_i)                           start_d = 1'b0;
    else if (wr_c && reg_wdata[0] && !start_q) start_d = 1'b1;
    else                                       start_d = start_q;
    if (rsp_take)       await_d = 1'b0;
    else if (rd_sent_i) await_d = 1'b1;
    else                await_d = await_q;
    if (rsp_take)                  ready_d = 1'b1;
    else if (wr_s && reg_wdata[0]) ready_d = 1'b0;
    else                           ready_d = ready_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q <= 1'b0; ca_q <= '0; req_q <= '0; cd_q <= '0;
      start_q <= 1'b0; atomic_q <= 1'b0; await_q <= 1'b0; ready_q <= 1'b0;
    end else begin
      if (en_a) begin
        rw_q  <= rw_d;
        ca_q  <= ca_d;
        req_q <= req_d;
      end
      if (en_d) cd_q <= cd_d;
      if (en_c) begin
        start_q  <= start_d;
        atomic_q <= atomic_d;
      end
      if (en_flags) begin
        await_q <= await_d;
        ready_q <= ready_d;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CMDA: begin
        reg_rdata[RW_POS]             = rw_q;
        reg_rdata[CA_LO +: CA_W]      = ca_q;
        reg_rdata[REQ_LO +: REQ_W]    = req_q;
      end
      REG_CMDD: reg_rdata[CD_W-1:0] = cd_q;
      REG_CTRL: reg_rdata[1:0]      = {atomic_q, start_q};
      default:  reg_rdata[0]        = ready_q;
    endcase
  end

  assign start_o  = start_q;
  assign atomic_o = atomic_q;
  assign rw_o     = rw_q;
  assign ca_o     = ca_q;
  assign cd_o     = cd_q;

  p_resv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == REG_CMDA) |-> (reg_rdata[31:20] == '0));
  p_start_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && !clr_start_i) |=> start_q);
  p_ready_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(await_q));
  p_w1c_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && reg_wdata[0] && !rsp_take) |=> !ready_q);
endmodule

// File: rtl/cslot_tx.sv
module cslot_tx
  import cslot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             atomic_i,
  input  logic             rw_i,
  input  logic [CA_W-1:0]  ca_i,
  input  logic [CD_W-1:0]  cd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             clr_start_o,
  output logic             rd_sent_o,
  output logic             sync_o,
  output logic             sdo_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  cmd_snap_t         snap_q, snap_d;
  logic              half_q, half_d;
  logic              sync_q, sync_d, sdo_q, sdo_d;
  logic              last_w, load_w;
  logic [HEAD_W-1:0] head_w;
  logic [HIDX_W-1:0] hidx_w;
  logic [TAG_W-1:0]  tag_w;
  logic [SLOT_W-1:0] s1_w, s2_w;

  assign last_w      = (cnt_q == CNT_W'(FRAME_LEN - 1));
  assign load_w      = last_w && start_i && !snap_q.v1;
  assign clr_start_o = last_w && snap_q.v1;
  assign rd_sent_o   = clr_start_o && snap_q.rw;

  always_comb begin
    cnt_d  = last_w ? '0 : cnt_q + 1'b1;
    snap_d = snap_q;
    half_d = half_q;
    if (last_w) begin
      snap_d = '0;
      if (load_w) begin
        snap_d.rw = rw_i;
        snap_d.ca = ca_i;
        snap_d.cd = cd_i;
        if (rw_i) begin
          snap_d.v1 = 1'b1;
        end else if (atomic_i) begin
          snap_d.v1 = 1'b1;
          snap_d.v2 = 1'b1;
          half_d    = 1'b0;
        end else if (!half_q) begin
          snap_d.v2 = 1'b1;
          half_d    = 1'b1;
        end else begin
          snap_d.v1 = 1'b1;
          half_d    = 1'b0;
        end
      end
    end
  end

  always_comb begin
    tag_w  = {snap_q.v1 | snap_q.v2, snap_q.v1, snap_q.v2, {(TAG_W-3){1'b0}}};
    s1_w   = {snap_q.rw, snap_q.ca, {(SLOT_W-1-CA_W){1'b0}}} & {SLOT_W{snap_q.v1}};
    s2_w   = {snap_q.cd, {(SLOT_W-CD_W){1'b0}}} & {SLOT_W{snap_q.v2}};
    head_w = {tag_w, s1_w, s2_w};
    hidx_w = HIDX_W'(HEAD_W - 1) - cnt_q[HIDX_W-1:0];
    sdo_d  = (cnt_q < CNT_W'(HEAD_W)) ? head_w[hidx_w] : 1'b0;
    sync_d = (cnt_q < CNT_W'(TAG_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
      half_q <= 1'b0;
      sync_q <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
      sdo_q  <= sdo_d;
      if (last_w) begin
        snap_q <= snap_d;
        half_q <= half_d;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign sync_o = sync_q;
  assign sdo_o  = sdo_q;

  p_sync_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(TAG_W + 1)) |-> (!sync_q && $past(sync_q)));
  p_atomic_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_w && atomic_i && !rw_i) |=> (snap_q.v1 && snap_q.v2));
  p_single_send_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_start_o |=> !snap_q.v1);
endmodule

// File: rtl/cslot_rx.sv
module cslot_rx
  import cslot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdi_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             rsp_valid_o,
  output logic [CA_W-1:0]  rsp_ca_o,
  output logic [REQ_W-1:0] rsp_req_o,
  output logic [CD_W-1:0]  rsp_cd_o
);
  localparam int KEEP_W = CA_W + REQ_W;

  logic              sdi_q;
  logic [SLOT_W-1:0] sr_q, sr_nx;
  logic              tag_ok_q, tag_ok_d;
  logic [KEEP_W-1:0] s1_q, s1_d;
  logic              at_tag, at_s1, at_s2;
  logic              unused_lo;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sdi_q <= 1'b0;
    else        sdi_q <= sdi_i;
  end

  assign sr_nx     = {sr_q[SLOT_W-2:0], sdi_q};
  assign unused_lo = ^sr_nx[1:0];
  assign at_tag    = (cnt_i == CNT_W'(TAG_W));
  assign at_s1     = (cnt_i == CNT_W'(S1_END));
  assign at_s2     = (cnt_i == CNT_W'(S2_END));

  always_comb begin
    tag_ok_d = at_tag ? (sr_nx[TAG_W-2] & sr_nx[TAG_W-3]) : tag_ok_q;
    s1_d     = at_s1 ? sr_nx[CA_LO+CA_W-1:REQ_LO] : s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      tag_ok_q <= 1'b0;
      s1_q     <= '0;
    end else begin
      sr_q <= sr_nx;
      if (at_tag) tag_ok_q <= tag_ok_d;
      if (at_s1)  s1_q     <= s1_d;
    end
  end

  assign rsp_valid_o = at_s2 && tag_ok_q;
  assign rsp_ca_o    = s1_q[KEEP_W-1 -: CA_W];
  assign rsp_req_o   = s1_q[REQ_W-1:0];
  assign rsp_cd_o    = sr_nx[SLOT_W-1 -: CD_W];
endmodule

// File: rtl/cslot_ctrl.sv
module cslot_ctrl
  import cslot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sync_o,
  output logic        sdo_o,
  input  logic        sdi_i
);
  logic             rst_s1, rst_s2;
  logic [CNT_W-1:0] cnt_w;
  logic             clr_start_w, rd_sent_w, start_w, atomic_w, rw_w;
  logic [CA_W-1:0]  ca_w, rsp_ca_w;
  logic [CD_W-1:0]  cd_w, rsp_cd_w;
  logic [REQ_W-1:0] rsp_req_w;
  logic             rsp_valid_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  cslot_regs u_regs (
    .clk(clk), .rst_n(rst_s2), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clr_start_i(clr_start_w), .rd_sent_i(rd_sent_w),
    .rsp_valid_i(rsp_valid_w), .rsp_ca_i(rsp_ca_w), .rsp_req_i(rsp_req_w),
    .rsp_cd_i(rsp_cd_w), .start_o(start_w), .atomic_o(atomic_w),
    .rw_o(rw_w), .ca_o(ca_w), .cd_o(cd_w)
  );

  cslot_tx u_tx (
    .clk(clk), .rst_n(rst_s2), .start_i(start_w), .atomic_i(atomic_w),
    .rw_i(rw_w), .ca_i(ca_w), .cd_i(cd_w), .cnt_o(cnt_w),
    .clr_start_o(clr_start_w), .rd_sent_o(rd_sent_w),
    .sync_o(sync_o), .sdo_o(sdo_o)
  );

  cslot_rx u_rx (
    .clk(clk), .rst_n(rst_s2), .sdi_i(sdi_i), .cnt_i(cnt_w),
    .rsp_valid_o(rsp_valid_w), .rsp_ca_o(rsp_ca_w), .rsp_req_o(rsp_req_w),
    .rsp_cd_o(rsp_cd_w)
  );
endmodule

// File: tb/cslot_ctrl_tb_top.sv
`timescale 1ns/100ps
module cslot_ctrl_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, reg_we, sync_o, sdo_o, sdi_i;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  cslot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sync_o(sync_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
  );

  integer total = 0, bad = 0;
  string  tag_now = "R3";

  // behavioural model state
  bit       m_start, m_atomic, m_rw, m_half, m_await, m_ready;
  bit [6:0] m_ca;
  bit [9:0] m_req;
  bit [15:0] m_cd;
  bit       sv1, sv2, srw;
  bit [6:0] sca;
  bit [15:0] scd;
  bit       rsp_arm, rsp_t1, rsp_t2;
  bit [6:0] rsp_ca;
  bit [9:0] rsp_req;
  bit [15:0] rsp_cd;

  logic [255:0] txf = '0, rxf = '0;
  integer pos = 0, fcount = 0, mis_pos = 0;
  bit     anchored = 0, mis = 0;
  logic [1:0] mis_act, mis_exp;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  function automatic void new_frame();
    bit v1, v2;
    bit [19:0] s1, s2, r1, r2;
    if (sv1) begin
      m_start = 0;
      if (srw) m_await = 1;
    end
    v1 = 0; v2 = 0;
    if (!sv1 && m_start) begin
      if (m_rw) v1 = 1;
      else if (m_atomic) begin v1 = 1; v2 = 1; m_half = 0; end
      else if (!m_half) begin v2 = 1; m_half = 1; end
      else begin v1 = 1; m_half = 0; end
    end
    sv1 = v1; sv2 = v2; srw = m_rw; sca = m_ca; scd = m_cd;
    txf = '0;
    txf[0] = v1 | v2; txf[1] = v1; txf[2] = v2;
    s1 = {srw, sca, 12'b0};
    s2 = {scd, 4'b0};
    for (int j = 0; j < 20; j++) begin
      txf[16+j] = v1 & s1[19-j];
      txf[36+j] = v2 & s2[19-j];
    end
    rxf = '0;
    if (rsp_arm) begin
      rxf[0] = 1; rxf[1] = rsp_t1; rxf[2] = rsp_t2;
      r1 = {1'b0, rsp_ca, rsp_req, 2'b0};
      r2 = {rsp_cd, 4'b0};
      for (int j = 0; j < 20; j++) begin
        rxf[16+j] = r1[19-j];
        rxf[36+j] = r2[19-j];
      end
      if (rsp_t1 && rsp_t2 && m_await) begin
        m_await = 0; m_ready = 1; m_ca = rsp_ca; m_req = rsp_req; m_cd = rsp_cd;
      end
      rsp_arm = 0;
    end
  endfunction

  function automatic void end_frame();
    total++;
    if (mis) begin
      bad++;
      $display("FAIL %s: frame %0d pos %0d {sync,sdo}=%b expected %b",
               tag_now, fcount, mis_pos, mis_act, mis_exp);
    end
    mis = 0;
    fcount++;
  endfunction

  // cycle-by-cycle comparison of the serial stream
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!anchored) begin
        if (rst_n && sync_o) begin anchored = 1; pos = 0; new_frame(); end
      end else begin
        pos = pos + 1;
        if (pos == 256) begin pos = 0; end_frame(); new_frame(); end
      end
      sdi_i = anchored ? rxf[pos] : 1'b0;
      @(negedge clk);
      if (anchored && !mis && ({sync_o, sdo_o} !== {pos < 16, txf[pos]})) begin
        mis = 1; mis_pos = pos; mis_act = {sync_o, sdo_o}; mis_exp = {pos < 16, txf[pos]};
      end
    end
  end

  task automatic wait_pos(input integer p);
    do @(negedge clk); while (!(anchored && pos == p));
  endtask

  task automatic step();
    integer f;
    f = fcount;
    do @(negedge clk); while (fcount == f);
    wait_pos(100);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    case (a)
      2'd0: begin m_rw = d[19]; m_ca = d[18:12]; end
      2'd1: m_cd = d[15:0];
      2'd2: begin m_atomic = d[1]; if (d[0] && !m_start) m_start = 1; end
      default: if (d[0]) m_ready = 0;
    endcase
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_chk(input string r, input logic [1:0] a);
    logic [31:0] e;
    case (a)
      2'd0: e = {12'b0, m_rw, m_ca, m_req, 2'b0};
      2'd1: e = {16'b0, m_cd};
      2'd2: e = {30'b0, m_atomic, m_start};
      default: e = {31'b0, m_ready};
    endcase
    reg_addr = a; #1;
    chk(r, reg_rdata, e);
  endtask

  task automatic arm(input bit t1, input bit t2, input bit [6:0] ca,
                     input bit [9:0] rq, input bit [15:0] cd);
    rsp_arm = 1; rsp_t1 = t1; rsp_t2 = t2; rsp_ca = ca; rsp_req = rq; rsp_cd = cd;
  endtask

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; sdi_i = 0;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      chk("R1 reg", reg_rdata, 32'h0);
    end
    chk("R1 sync/sdo", {30'b0, sync_o, sdo_o}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    wait_pos(100);
    tag_now = "R2 R3";
    step(); step();

    // R4 register layout
    wr(2'd0, 32'hFFFF_FFFF); rd_chk("R4 addr all ones", 2'd0);
    wr(2'd0, 32'h0);         rd_chk("R4 addr zero", 2'd0);
    wr(2'd1, 32'hFFFF_FFFF); rd_chk("R4 data mask", 2'd1);

    // R5 read command, R10 response, R8 start clear
    tag_now = "R5";
    wr(2'd0, {12'b0, 1'b1, 7'h2A, 12'b0});
    wr(2'd2, 32'h1);
    rd_chk("R8 start pending", 2'd2);
    step();
    arm(1, 1, 7'h55, 10'h2B5, 16'hBEEF);
    tag_now = "R10";
    step();
    rd_chk("R8 start cleared", 2'd2);
    rd_chk("R10 ready", 2'd3);
    rd_chk("R10 status addr", 2'd0);
    rd_chk("R10 status data", 2'd1);

    // R12 clear on write one
    wr(2'd3, 32'h0); rd_chk("R12 write zero keeps", 2'd3);
    wr(2'd3, 32'h1); rd_chk("R12 write one clears", 2'd3);

    // R11 response without pending read
    tag_now = "R11";
    arm(1, 1, 7'h3C, 10'h0F0, 16'h1111);
    step();
    rd_chk("R11 no read ready", 2'd3);
    rd_chk("R11 no read addr", 2'd0);
    // R11 response missing slot2 valid
    wr(2'd0, {12'b0, 1'b1, 7'h0F, 12'b0});
    wr(2'd2, 32'h1);
    step();
    arm(1, 0, 7'h7E, 10'h3FF, 16'h2222);
    step();
    rd_chk("R11 partial tag ready", 2'd3);
    rd_chk("R11 partial tag addr", 2'd0);
    arm(1, 1, 7'h01, 10'h155, 16'h0F0F);
    step();
    rd_chk("R10 late response ready", 2'd3);
    rd_chk("R10 late response addr", 2'd0);
    rd_chk("R10 late response data", 2'd1);
    wr(2'd3, 32'h1);

    // R6 atomic write
    tag_now = "R6";
    wr(2'd1, 32'h1234);
    wr(2'd0, {12'b0, 1'b0, 7'h11, 12'b0});
    wr(2'd2, 32'h3);
    wr(2'd2, 32'h3);
    step();
    step();
    rd_chk("R8 atomic start cleared", 2'd2);

    // R7 split write, R9 repeated start
    tag_now = "R7";
    wr(2'd2, 32'h0);
    wr(2'd1, 32'hA5C3);
    wr(2'd0, {12'b0, 1'b0, 7'h33, 12'b0});
    wr(2'd2, 32'h1);
    step();
    wr(2'd2, 32'h1);
    rd_chk("R9 start still pending", 2'd2);
    wr(2'd2, 32'h0);
    rd_chk("R9 write zero no effect", 2'd2);
    step();
    tag_now = "R9";
    step();
    rd_chk("R8 split start cleared", 2'd2);
    step();
    step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule